// File: doc/BRIEF.md
# SMBus Block-Access Configuration Register Slave

This block is a two-wire bus slave that holds a small bank of byte-wide configuration registers for the rest of the device. The bus lines are oversampled by a fast system clock. The slave drives SDA only through an open-drain enable. A host reaches the bank with indexed block transfers. Each write carries a starting index and a byte count. A read first returns a byte count taken from a writable count register, then streams register contents from the index set earlier.

Each register bit is either host-writable or fixed. Fixed bits come from three sources: constants, latched strap inputs (frequency select and an alternate-function strap), and a revision code input. Every register's current value is presented in parallel on a flat output bus. The index advances after every data byte. Indices past the implemented bank read as zero and accept no writes.

Top module: `smb_cfg_slave`

## Requirements
- R1: Address byte D2h (write) and D3h (read) are acknowledged. Any other address byte gets a NACK, and the slave drives nothing until the next START.
- R2: After D2h, the slave takes an index byte, then a count byte, then data bytes. Each data byte is written at the current index, and the index then increments. The slave acknowledges the index, the count and every data byte within the count.
- R3: Data bytes that arrive after the written count is used up are NACKed and change no register.
- R4: After D3h, the slave sends a count byte equal to the lower six bits of register 12, limited to 32. It then sends the register at the current index, followed by consecutive registers, until the host answers a byte with NACK. After that NACK, SDA is released.
- R5: Reset values, register 0 to 12 (fixed fields excluded): 01h, 39h, FFh, FFh, DEh, 00h, 00h, 01h, 62h, 25h, 03h, 17h, 0Dh.
- R6: Writable-bit masks, register 0 to 12: 1Bh, E0h, FFh, FFh, FFh, FFh, FFh, 00h, 0Fh, BFh, 7Fh, FDh, 3Fh. A write leaves every other bit at its fixed value.
- R7: Indices 13 and above read as 00h, and writes to them are acknowledged within the count but ignored.
- R8: Register 0 bits 7:5 show the frequency straps. Register 7 shows the revision code in bits 7:4 and 0001 in bits 3:0. Register 8 bits 7:4 read 0110. Register 10 bit 7 shows the alternate-function strap.
- R9: A START at any point restarts address reception and keeps the index. A STOP returns the slave to idle with SDA released.
- R10: The slave changes its SDA drive only while SCL is low, except when released by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_fs_i | input | 3 | Latched frequency-select straps |
| strap_alt_i | input | 1 | Latched alternate-function strap |
| rev_id_i | input | 4 | Revision code |
| regs_o | output | 104 | Visible register contents, register i at bits 8i+7:8i |

## Verification
Some behaviours are checked by assertions on every cycle. These are: SDA drive held steady while SCL is high, the released and idle state after STOP, no SDA drive while idle, fixed bits unchanged across writes, writes past the bank having no effect, and the count byte never exceeding 32. Other behaviours can only be shown by the bench's bus scenarios. These are: which bytes are ACKed or NACKed, the returned data sequence, index auto-increment across repeated START, the count clamp, zero reads past the bank, and the masked merge of written data. The bench checks those against a behavioural register model.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;
  localparam logic [7:0]  WR_ADDR = 8'hD2;
  localparam logic [7:0]  RD_ADDR = 8'hD3;
  localparam int unsigned CNT_REG = 12;
  localparam int unsigned CNT_MAX = 32;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INDEX, PH_WCNT, PH_WDATA, PH_RCNT, PH_RDATA
  } phase_e;

  function automatic logic [7:0] rw_mask(int unsigned i);
    case (i)
      0:  return 8'h1B;
      1:  return 8'hE0;
      2, 3, 4, 5, 6: return 8'hFF;
      7:  return 8'h00;
      8:  return 8'h0F;
      9:  return 8'hBF;
      10: return 8'h7F;
      11: return 8'hFD;
      12: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(int unsigned i);
    case (i)
      0:  return 8'h01;
      1:  return 8'h39;
      2:  return 8'hFF;
      3:  return 8'hFF;
      4:  return 8'hDE;
      5:  return 8'h00;
      6:  return 8'h00;
      7:  return 8'h01;
      8:  return 8'h62;
      9:  return 8'h25;
      10: return 8'h03;
      11: return 8'h17;
      12: return 8'h0D;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
`timescale 1ns/1ps
module smb_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int unsigned i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smb_regs.sv
`timescale 1ns/1ps
module smb_regs
  import smb_cfg_pkg::*;
#(
  parameter int unsigned N_REGS = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [7:0]          wr_idx_i,
  input  logic [7:0]          wr_data_i,
  input  logic [7:0]          rd_idx_i,
  output logic [7:0]          rd_data_o,
  output logic [7:0]          cnt_o,
  input  logic [2:0]          strap_fs_i,
  input  logic                strap_alt_i,
  input  logic [3:0]          rev_id_i,
  output logic [N_REGS*8-1:0] regs_o
);
  logic [7:0] fixed_c [N_REGS];
  logic [7:0] vis     [N_REGS];
  logic [7:0] cnt_raw;

  // fixed-bit sources: constants with strap/revision overlays
  always_comb begin
    for (int unsigned i = 0; i < N_REGS; i++) fixed_c[i] = rst_val(i);
    fixed_c[0][7:5] = strap_fs_i;
    if (N_REGS > 7)  fixed_c[7][7:4]  = rev_id_i;
    if (N_REGS > 10) fixed_c[10][7]   = strap_alt_i;
  end

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [7:0] MSK = rw_mask(g);
    localparam logic [7:0] RST = rst_val(g);
    localparam logic [7:0] IDX = 8'(g);
    logic [7:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= RST & MSK;
      else if (wr_en_i && (wr_idx_i == IDX))   q <= (q & ~MSK) | (wr_data_i & MSK);
    end

    assign vis[g] = (q & MSK) | (fixed_c[g] & ~MSK);
    assign regs_o[g*8 +: 8] = vis[g];

    a_r6_fixed_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (!$stable({strap_fs_i, strap_alt_i, rev_id_i}) ||
                   ((vis[g] & ~MSK) == ($past(vis[g]) & ~MSK))))
      else $error("a_r6_fixed_bits_hold reg %0d", g);
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int unsigned i = 0; i < N_REGS; i++)
      if (rd_idx_i == 8'(i)) rd_data_o = vis[i];
  end

  assign cnt_raw = vis[CNT_REG] & 8'h3F;
  assign cnt_o   = (cnt_raw > 8'(CNT_MAX)) ? 8'(CNT_MAX) : cnt_raw;

  a_r7_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i >= 8'(N_REGS))) |=>
      (!$stable({strap_fs_i, strap_alt_i, rev_id_i}) || $stable(regs_o)))
    else $error("a_r7_oob_write_ignored");
endmodule

// File: rtl/smb_link.sv
`timescale 1ns/1ps
module smb_link
  import smb_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_idx_o,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] cnt_i
);
  logic       scl_d, sda_d;
  logic       rise, fall, start_det, stop_det;
  phase_e     ph_q, nxt_q, nxt_c;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, idx_q, left_q;
  logic       oe_q;
  logic       tx_ph, ack_c, wr_c, drop_c, byte_end, ld_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign rise      = scl_i & ~scl_d;
  assign fall      = ~scl_i & scl_d;
  assign start_det = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_det  = scl_i & scl_d & ~sda_d & sda_i;
  assign tx_ph     = (ph_q == PH_RCNT) || (ph_q == PH_RDATA);
  assign ld_cnt    = !tx_ph && (nxt_q == PH_RCNT);

  // byte-end decision for received bytes
  always_comb begin
    ack_c  = 1'b0;
    wr_c   = 1'b0;
    drop_c = 1'b0;
    nxt_c  = ph_q;
    unique case (ph_q)
      PH_ADDR: begin
        if (sh_q == WR_ADDR)      begin ack_c = 1'b1; nxt_c = PH_INDEX; end
        else if (sh_q == RD_ADDR) begin ack_c = 1'b1; nxt_c = PH_RCNT;  end
        else                      drop_c = 1'b1;
      end
      PH_INDEX: begin ack_c = 1'b1; nxt_c = PH_WCNT;  end
      PH_WCNT:  begin ack_c = 1'b1; nxt_c = PH_WDATA; end
      PH_WDATA: begin
        nxt_c = PH_WDATA;
        if (left_q != 8'd0) begin ack_c = 1'b1; wr_c = 1'b1; end
      end
      default: ;
    endcase
  end

  assign byte_end  = fall && (bit_q == 4'd8) && !tx_ph && (ph_q != PH_IDLE)
                     && !start_det && !stop_det;
  assign wr_en_o   = byte_end && wr_c;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = sh_q;
  assign rd_idx_o  = idx_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      nxt_q  <= PH_IDLE;
      bit_q  <= 4'd0;
      sh_q   <= 8'h00;
      tx_q   <= 8'h00;
      idx_q  <= 8'h00;
      left_q <= 8'h00;
      oe_q   <= 1'b0;
    end else if (start_det) begin
      ph_q  <= PH_ADDR;
      bit_q <= 4'd0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      ph_q  <= PH_IDLE;
      bit_q <= 4'd0;
      oe_q  <= 1'b0;
    end else if (ph_q != PH_IDLE) begin
      if (rise && (bit_q < 4'd8)) begin
        sh_q  <= {sh_q[6:0], sda_i};
        bit_q <= bit_q + 4'd1;
      end else if (rise && (bit_q == 4'd9) && tx_ph && sda_i) begin
        ph_q  <= PH_IDLE;           // host NACK ends the read
        bit_q <= 4'd0;
      end else if (fall) begin
        if (bit_q == 4'd8) begin
          bit_q <= 4'd9;
          if (tx_ph) begin
            oe_q <= 1'b0;
          end else if (drop_c) begin
            ph_q  <= PH_IDLE;
            bit_q <= 4'd0;
          end else begin
            oe_q  <= ack_c;
            nxt_q <= nxt_c;
            if (ph_q == PH_INDEX) idx_q  <= sh_q;
            if (ph_q == PH_WCNT)  left_q <= sh_q;
            if (wr_c) begin
              idx_q  <= idx_q + 8'd1;
              left_q <= left_q - 8'd1;
            end
          end
        end else if (bit_q == 4'd9) begin
          bit_q <= 4'd0;
          if (ld_cnt) begin
            tx_q <= cnt_i;
            oe_q <= ~cnt_i[7];
            ph_q <= PH_RCNT;
          end else if (tx_ph) begin
            tx_q  <= rd_data_i;
            oe_q  <= ~rd_data_i[7];
            idx_q <= idx_q + 8'd1;
            ph_q  <= PH_RDATA;
          end else begin
            oe_q <= 1'b0;
            ph_q <= nxt_q;
          end
        end else if (tx_ph && (bit_q != 4'd0)) begin
          oe_q <= ~tx_q[3'd7 - bit_q[2:0]];
        end
      end
    end
  end

  a_r1_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE) |-> !oe_q)
    else $error("a_r1_idle_no_drive");

  a_r9_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!oe_q && (ph_q == PH_IDLE)))
    else $error("a_r9_stop_releases");

  a_r10_drive_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && scl_d && !$past(start_det || stop_det)) |-> $stable(oe_q))
    else $error("a_r10_drive_steady_scl_high");

  a_r4_count_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && (bit_q == 4'd9) && ld_cnt && (ph_q != PH_IDLE)) |=> (tx_q <= 8'd32))
    else $error("a_r4_count_clamped");
endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave #(
  parameter int unsigned N_REGS = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [2:0]          strap_fs_i,
  input  logic                strap_alt_i,
  input  logic [3:0]          rev_id_i,
  output logic [N_REGS*8-1:0] regs_o
);
  logic [1:0] line_s;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt;

  smb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  smb_link u_link (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (line_s[1]),
    .sda_i    (line_s[0]),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data),
    .rd_idx_o (rd_idx),
    .rd_data_i(rd_data),
    .cnt_i    (cnt)
  );

  smb_regs #(.N_REGS(N_REGS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .cnt_o      (cnt),
    .strap_fs_i (strap_fs_i),
    .strap_alt_i(strap_alt_i),
    .rev_id_i   (rev_id_i),
    .regs_o     (regs_o)
  );
endmodule

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
  localparam int NR = 13;
  localparam int Q  = 10;
  localparam int H  = 20;
  localparam logic [7:0] MK [NR] = '{8'h1B, 8'hE0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                                     8'h00, 8'h0F, 8'hBF, 8'h7F, 8'hFD, 8'h3F};
  localparam logic [7:0] RV [NR] = '{8'h01, 8'h39, 8'hFF, 8'hFF, 8'hDE, 8'h00, 8'h00,
                                     8'h01, 8'h62, 8'h25, 8'h03, 8'h17, 8'h0D};
  localparam logic [2:0] FS  = 3'b101;
  localparam logic       ALT = 1'b1;
  localparam logic [3:0] REV = 4'h2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NR*8-1:0] regs;
  logic quiet = 1'b0;
  logic done = 1'b0;
  int   checks = 0, errs = 0, cyc = 0;
  logic [7:0] mdl [NR];

  always #2 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  smb_cfg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_fs_i(FS), .strap_alt_i(ALT), .rev_id_i(REV), .regs_o(regs)
  );

  function automatic logic [7:0] vis(int i);
    logic [7:0] f;
    if (i < 0 || i >= NR) return 8'h00;
    f = RV[i];
    if (i == 0)  f[7:5] = FS;
    if (i == 7)  f[7:4] = REV;
    if (i == 10) f[7]   = ALT;
    return (mdl[i] & MK[i]) | (f & ~MK[i]);
  endfunction

  function automatic logic [7:0] exp_cnt();
    logic [7:0] c;
    c = vis(12) & 8'h3F;
    return (c > 8'd32) ? 8'd32 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(H); sda_h = 1'b0; tick(H); scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(H); sda_h = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q); scl_h = 1'b1; tick(H); scl_h = 1'b0; tick(Q);
    end
    sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(H/2);
    ack = ~sda_bus;
    tick(H/2); scl_h = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_h = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl_h = 1'b0; tick(Q);
    end
    tick(2); sda_h = ~give_ack; tick(Q); scl_h = 1'b1; tick(H); scl_h = 1'b0; tick(2);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic mdl_wr(input int i, input logic [7:0] d);
    if (i < NR) mdl[i] = (mdl[i] & ~MK[i]) | (d & MK[i]);
  endtask

  task automatic wr_block(input logic [7:0] idx, input logic [7:0] cnt, input logic [7:0] dq [$]);
    logic a;
    quiet = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(idx, a);   chk(a, "R2 index ack", a, 1);
    send_byte(cnt, a);   chk(a, "R2 count ack", a, 1);
    foreach (dq[k]) begin
      send_byte(dq[k], a);
      if (k < int'(cnt)) begin
        chk(a, "R2 data ack", a, 1);
        mdl_wr(int'(idx) + k, dq[k]);
      end else begin
        chk(!a, "R3 excess byte nack", a, 0);
      end
    end
    bus_stop();
    tick(8); quiet = 1'b1; tick(8);
  endtask

  task automatic rd_block(input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] b;
    quiet = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(idx, a);   chk(a, "R2 index ack", a, 1);
    bus_start();         // R9 repeated start
    send_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, b);  chk(b == exp_cnt(), "R4 count byte", b, exp_cnt());
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      if (int'(idx) + k >= NR) chk(b == 8'h00, "R7 out-of-range read", b, 0);
      else chk(b == vis(int'(idx) + k), "R4 read data", b, vis(int'(idx) + k));
    end
    chk(sda_oe == 1'b0, "R4 released after host nack", sda_oe, 0);
    bus_stop();
    tick(8); quiet = 1'b1; tick(8);
  endtask

  // per-cycle comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (rst_n && quiet && !done) begin
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NR; i++) if (regs[i*8 +: 8] !== vis(i)) ok = 1'b0;
      if (!ok) begin
        for (int i = 0; i < NR; i++)
          if (regs[i*8 +: 8] !== vis(i)) chk(1'b0, "R6 register image", regs[i*8 +: 8], vis(i));
      end else chk(1'b1, "R6 register image", 0, 0);
      chk(sda_oe == 1'b0, "R9 idle release", sda_oe, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog R1 actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic a;
    for (int i = 0; i < NR; i++) mdl[i] = RV[i] & MK[i];
    tick(5); rst_n = 1'b1; tick(5);
    chk(sda_oe == 1'b0, "R5 reset no drive", sda_oe, 0);
    chk(regs[12*8 +: 8] == 8'h0D, "R5 reset count reg", regs[12*8 +: 8], 8'h0D);
    chk(regs[4*8 +: 8] == 8'hDE, "R5 reset reg4", regs[4*8 +: 8], 8'hDE);
    chk(regs[7*8 +: 8] == {REV, 4'b0001}, "R8 id reg7", regs[7*8 +: 8], {REV, 4'b0001});
    chk(regs[8*8+4 +: 4] == 4'b0110, "R8 id reg8", regs[8*8+4 +: 4], 4'b0110);
    chk(regs[7:5] == FS, "R8 strap readback", regs[7:5], FS);
    chk(regs[10*8+7] == ALT, "R8 alt strap", regs[10*8+7], ALT);
    quiet = 1'b1; tick(10);

    rd_block(8'd0, 13);                                   // R5 full readout
    wr_block(8'd2, 8'd3, '{8'hA5, 8'h5A, 8'h3C});          // R2
    wr_block(8'd0, 8'd2, '{8'hFF, 8'hFF});                 // R6 masked bits
    wr_block(8'd7, 8'd4, '{8'hFF, 8'h00, 8'hFF, 8'h00});   // R6 fixed ids, reg9/10
    wr_block(8'd5, 8'd1, '{8'h11, 8'h22});                 // R3 excess byte
    rd_block(8'd2, 4);

    quiet = 1'b0;                                          // R1 foreign address
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R1 no response after nack", a, 0);
    chk(sda_oe == 1'b0, "R1 no drive", sda_oe, 0);
    bus_stop(); tick(8); quiet = 1'b1; tick(8);

    quiet = 1'b0;                                          // R9 restart keeps protocol
    bus_start();
    send_byte(8'hD2, a); chk(a, "R9 first address", a, 1);
    send_byte(8'd3, a);  chk(a, "R9 first index", a, 1);
    bus_start();
    send_byte(8'hD2, a); chk(a, "R9 address after restart", a, 1);
    send_byte(8'd4, a);  chk(a, "R9 index after restart", a, 1);
    send_byte(8'd1, a);  chk(a, "R9 count after restart", a, 1);
    send_byte(8'h66, a); chk(a, "R9 data after restart", a, 1);
    mdl_wr(4, 8'h66);
    bus_stop(); tick(8); quiet = 1'b1; tick(8);

    wr_block(8'd11, 8'd4, '{8'h00, 8'h25, 8'h77, 8'h88}); // R7 writes past bank
    rd_block(8'd11, 4);                                   // R4 clamp to 32, R7 zeros
    wr_block(8'd12, 8'd1, '{8'hE0});
    rd_block(8'd10, 3);                                   // R4 count 32 exactly
    wr_block(8'd12, 8'd1, '{8'h0D});
    rd_block(8'd0, 13);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule